// File: doc/BRIEF.md
# Dual-law serial clock divider

This block derives the serial clock of an SPI controller from the bus clock. A single law-select input chooses how the divider value is read. The exponential law gives a half-period of 2^N bus cycles, where N is the low four bits of the value, so the full ratio is 2^(N+1). The linear law gives a half-period of N+1 bus cycles, where N is the full eight-bit value, so the full ratio is 2*(N+1). The shortest half-period is one bus cycle, so the serial clock can never run faster than half the bus clock.

The block drives a free-running serial clock with a 50% duty cycle for the shift engine. It also drives two strobes, one cycle wide, that mark the bus cycle just before each rising and falling transition. The shift engine uses these strobes as clock enables in the bus-clock domain. A half-period counter reloads from the selected law at every half-period boundary. A new divider value or law therefore takes effect only at the next boundary, and no runt pulse can appear. When the block is disabled, the counter is cleared and the serial clock rests low.

Top module: `sdiv_sclk_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released with the enable low, sclk is 0 and both strobes are 0.
- R2: With law_sel = 0 (exponential law), each half-period of sclk lasts 2^N bus cycles, with N = div_val[3:0]. Bits div_val[7:4] have no effect in this law.
- R3: With law_sel = 1 (linear law), each half-period of sclk lasts N+1 bus cycles, with N = div_val[7:0].
- R4: The bus clock edge that first samples en = 1 starts the run with sclk low. The first rising transition follows exactly one half-period later, and sclk then alternates high and low.
- R5: While the settings are steady, consecutive high and low phases have equal length, giving a 50% duty cycle.
- R6: A change of div_val or law_sel does not alter the half-period already in progress. The new half-period length applies from the next boundary onward.
- R7: In the cycle before sclk goes from 0 to 1, rise_stb is 1. In the cycle before sclk goes from 1 to 0, fall_stb is 1. The two strobes are never both 1, and sclk does not change while enabled unless a strobe was 1 in the previous cycle.
- R8: When en is 0, both strobes are 0 in the same cycle and sclk is 0 from the next bus clock edge. Both stay there until the block is enabled again, and the next run restarts as in R4.
- R9: The fastest setting, with a half-period of 1 (law 0 with N = 0, or law 1 with N = 0), toggles sclk on every bus clock edge, which gives half the bus clock rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low holds the divider idle |
| law_sel | input | 1 | 0 selects the exponential law, 1 selects the linear law |
| div_val | input | 8 | Divider value N |
| sclk | output | 1 | Free-running serial clock, idle low |
| rise_stb | output | 1 | High in the cycle before sclk rises |
| fall_stb | output | 1 | High in the cycle before sclk falls |

## Verification
After the edge that samples en = 1, sclk is expected to stay low for exactly one half-period of samples. After that it is expected to change level once every half-period. Each strobe is expected in the last sample of its half-period. The bench samples at the falling clock edge and walks through each half-period sample by sample. At each sample it compares sclk and both strobes with the values a bench function computes from the law and the value. For a change of settings in the middle of a run, the bench writes the new inputs at the second sample of a half-period. It still expects the old length for that half-period and the new length from the next one. For a disable, the bench expects the strobes to drop at once and sclk to drop one edge later.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

  typedef enum logic {
    LAW_EXP = 1'b0,
    LAW_LIN = 1'b1
  } sdiv_law_e;

  function automatic int sdiv_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdiv_law_decode.sv
module sdiv_law_decode
  import sdiv_pkg::*;
#(
  parameter int EXP_W = 4,
  parameter int LIN_W = 8,
  parameter int HP_W  = 16
) (
  input  logic              law_sel,
  input  logic [LIN_W-1:0]  div_val,
  output logic [HP_W-1:0]   reload_val
);

  localparam int EXP_HP_W = 1 << EXP_W;

  sdiv_law_e            law;
  logic [HP_W-1:0]      exp_reload;
  logic [HP_W-1:0]      lin_reload;
  logic [EXP_W-1:0]     exp_n;

  assign law   = sdiv_law_e'(law_sel);
  assign exp_n = div_val[EXP_W-1:0];

  generate
    if (EXP_HP_W <= HP_W) begin : g_exp_fit
      always_comb begin
        exp_reload = '0;
        for (int b = 0; b < EXP_HP_W; b++) begin
          exp_reload[b] = (b < int'(exp_n));
        end
      end
    end else begin : g_exp_clip
      always_comb begin
        exp_reload = '0;
        for (int b = 0; b < HP_W; b++) begin
          exp_reload[b] = (b < int'(exp_n));
        end
      end
    end
  endgenerate

  assign lin_reload = HP_W'(div_val);

  always_comb begin
    unique case (law)
      LAW_EXP: reload_val = exp_reload;
      LAW_LIN: reload_val = lin_reload;
      default: reload_val = exp_reload;
    endcase
  end

endmodule

// File: rtl/sdiv_half_counter.sv
module sdiv_half_counter #(
  parameter int HP_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [HP_W-1:0] reload_val,
  output logic            tick,
  output logic            running
);

  logic [HP_W-1:0] cnt_q, cnt_d;
  logic            run_q, run_d;
  logic            cnt_ce;

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    if (!en) begin
      cnt_d = '0;
      run_d = 1'b0;
    end else if (!run_q) begin
      cnt_d = reload_val;
      run_d = 1'b1;
    end else if (cnt_q == '0) begin
      cnt_d = reload_val;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  assign cnt_ce = en | run_q | (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assign tick    = run_q & en & (cnt_q == '0);
  assign running = run_q;

endmodule

// File: rtl/sdiv_phase.sv
module sdiv_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  output logic sclk,
  output logic rise_stb,
  output logic fall_stb
);

  logic sclk_q, sclk_d;
  logic ph_ce;

  always_comb begin
    if (!en) begin
      sclk_d = 1'b0;
    end else if (tick) begin
      sclk_d = ~sclk_q;
    end else begin
      sclk_d = sclk_q;
    end
  end

  assign ph_ce = tick | ~en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
    end else if (ph_ce) begin
      sclk_q <= sclk_d;
    end
  end

  assign sclk     = sclk_q;
  assign rise_stb = tick & ~sclk_q;
  assign fall_stb = tick &  sclk_q;

endmodule

// File: rtl/sdiv_sclk_gen.sv
module sdiv_sclk_gen
  import sdiv_pkg::*;
#(
  parameter int EXP_W = 4,
  parameter int LIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             law_sel,
  input  logic [LIN_W-1:0] div_val,
  output logic             sclk,
  output logic             rise_stb,
  output logic             fall_stb
);

  localparam int EXP_HP_W = 1 << EXP_W;
  localparam int LIN_HP_W = LIN_W + 1;
  localparam int HP_W     = sdiv_max(EXP_HP_W, LIN_HP_W);

  logic [HP_W-1:0] reload_val;
  logic            tick;
  logic            running;

  sdiv_law_decode #(
    .EXP_W (EXP_W),
    .LIN_W (LIN_W),
    .HP_W  (HP_W)
  ) u_decode (
    .law_sel    (law_sel),
    .div_val    (div_val),
    .reload_val (reload_val)
  );

  sdiv_half_counter #(
    .HP_W (HP_W)
  ) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .reload_val (reload_val),
    .tick       (tick),
    .running    (running)
  );

  sdiv_phase u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .tick     (tick),
    .sclk     (sclk),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

endmodule

// File: rtl/sdiv_sclk_gen_chk.sv
module sdiv_sclk_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic sclk,
  input logic rise_stb,
  input logic fall_stb
);

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !sclk) else $error("idle level");                         // R8

  AST_IDLE_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!rise_stb && !fall_stb)) else $error("idle strobe");     // R8

  AST_RISE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |=> sclk) else $error("rise strobe");                    // R7

  AST_FALL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |=> !sclk) else $error("fall strobe");                   // R7

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !rise_stb && !fall_stb) |=> $stable(sclk)) else $error("runt"); // R7

  AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_stb, fall_stb})) else $error("both strobes");      // R7

endmodule

bind sdiv_sclk_gen sdiv_sclk_gen_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (en),
  .sclk     (sclk),
  .rise_stb (rise_stb),
  .fall_stb (fall_stb)
);

// File: tb/sdiv_sclk_gen_bench.sv
module sdiv_sclk_gen_bench;

  logic       clk;
  logic       rst_n;
  logic       en;
  logic       law_sel;
  logic [7:0] div_val;
  logic       sclk;
  logic       rise_stb;
  logic       fall_stb;

  int n_chk;
  int n_err;
  bit exp_lvl;
  bit done;

  sdiv_sclk_gen u_sdiv_sclk_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .law_sel  (law_sel),
    .div_val  (div_val),
    .sclk     (sclk),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int half_len(input bit law, input logic [7:0] v);
    if (law) return int'(v) + 1;
    return 1 << v[3:0];
  endfunction

  task automatic chk(input int act, input int expv, input string tag);
    n_chk++;
    if (act != expv) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic start_run(input bit law, input logic [7:0] v);
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    law_sel = law;
    div_val = v;
    en      = 1'b1;
    exp_lvl = 1'b0;
  endtask

  task automatic run_halves(input int n, input int hp0, input int hp1,
                            input bit chg, input bit nl, input logic [7:0] nv,
                            input string tag);
    for (int h = 0; h < n; h++) begin
      int len;
      len = (h == 0) ? hp0 : hp1;
      for (int i = 0; i < len; i++) begin
        @(negedge clk);
        if (chg && h == 0 && i == 1) begin
          law_sel = nl;
          div_val = nv;
        end
        #1;
        chk(int'(sclk), int'(exp_lvl), {tag, " sclk"});
        chk(int'(rise_stb), int'((i == len-1) && !exp_lvl), {tag, " R7 rise_stb"});
        chk(int'(fall_stb), int'((i == len-1) && exp_lvl), {tag, " R7 fall_stb"});
      end
      exp_lvl = ~exp_lvl;
    end
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 190000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=%0d expected=done", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    bit         rl;
    logic [7:0] rv;
    int         hp;
    n_chk = 0;
    n_err = 0;
    done  = 1'b0;
    void'($urandom(32'h5d1c_0a7e));
    rst_n   = 1'b0;
    en      = 1'b0;
    law_sel = 1'b0;
    div_val = 8'd0;
    #1;
    chk(int'(sclk), 0, "R1 reset sclk");
    chk(int'(rise_stb | fall_stb), 0, "R1 reset strobes");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(int'(sclk), 0, "R1 after release sclk");
    chk(int'(rise_stb | fall_stb), 0, "R1 after release strobes");

    // R9: fastest settings in both laws
    start_run(1'b0, 8'd0);
    run_halves(6, 1, 1, 1'b0, 1'b0, 8'd0, "R9 exp N=0");
    start_run(1'b1, 8'd0);
    run_halves(6, 1, 1, 1'b0, 1'b0, 8'd0, "R9 lin N=0");

    // R2: upper bits ignored in exponential law (0x13 -> N=3 -> 8)
    start_run(1'b0, 8'h13);
    run_halves(4, 8, 8, 1'b0, 1'b0, 8'd0, "R2 exp upper bits");

    // R3: linear law maximum
    start_run(1'b1, 8'd255);
    run_halves(2, 256, 256, 1'b0, 1'b0, 8'd0, "R3 lin N=255");

    // R2: exponential law maximum (one high-low pair)
    start_run(1'b0, 8'd15);
    run_halves(2, 32768, 32768, 1'b0, 1'b0, 8'd0, "R2 exp N=15");

    // R4 R5: random settings from a fresh enable
    for (int t = 0; t < 16; t++) begin
      rl = 1'($urandom % 2);
      rv = rl ? 8'($urandom % 256) : 8'($urandom % 7);
      hp = half_len(rl, rv);
      start_run(rl, rv);
      run_halves(4, hp, hp, 1'b0, 1'b0, 8'd0, rl ? "R3 R4 R5 rand lin" : "R2 R4 R5 rand exp");
    end

    // R6: mid-half change, short to long and long to short
    start_run(1'b0, 8'd2);
    run_halves(4, 4, 6, 1'b1, 1'b1, 8'd5, "R6 exp4 to lin6");
    start_run(1'b1, 8'd9);
    run_halves(5, 10, 1, 1'b1, 1'b0, 8'd0, "R6 lin10 to exp1");

    // R8: disable while sclk is high, then re-enable
    start_run(1'b1, 8'd3);
    run_halves(1, 4, 4, 1'b0, 1'b0, 8'd0, "R8 pre");
    @(negedge clk);
    #1;
    chk(int'(sclk), 1, "R8 high before disable");
    en = 1'b0;
    #1;
    chk(int'(rise_stb | fall_stb), 0, "R8 strobes drop at once");
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      #1;
      chk(int'(sclk), 0, "R8 idle sclk");
      chk(int'(rise_stb | fall_stb), 0, "R8 idle strobes");
    end
    @(negedge clk);
    en = 1'b1;
    exp_lvl = 1'b0;
    run_halves(3, 4, 4, 1'b0, 1'b0, 8'd0, "R8 R4 restart");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule